// File: doc/BRIEF.md
# Two-Level Translation Lookaside Buffer Hierarchy

This block caches address translations in two levels. The first level has two small arrays, one serving instruction fetches and one serving data reads and writes. Behind them sits a larger shared second-level array. A lookup carries a virtual page number and a context key: address-space ID, virtual-machine ID, hypervisor and secure flags, exception level, an in-host flag and an ignore-ASID flag. The lookup is tried first in the first-level array of its side. On a miss it is tried in the second level. A non-functional second-level hit copies the entry into the first-level array of the requesting side.

Every entry carries a two-bit type tag. A non-functional hit whose tag lacks the requesting side is retagged unified, in the array that hit. Translations returned by the page walker are written into the first-level array of their side and into the second level. Each array keeps its own VMID register, and a VMID write updates all three at once. Walk fills are stamped with that register. Flush commands clear whole arrays: an instruction-side flush clears the instruction array, a data-side flush clears the data array, and a stage-1 flush clears both. The shared array is cleared by all three.

Top module: `tlb2_hier`

## Requirements
- R1: A lookup that hits in its first-level array (array 0 for `req_kind`=0 fetch, array 1 for 1 read or 2 write) returns `rsp_valid`=1, `rsp_hit`=1, `rsp_level`=0 and the stored page number on the clock edge that accepts it.
- R2: A first-level miss that hits the second level returns one edge later with `rsp_level`=1. If the lookup is non-functional, the entry is copied into the first-level array of its side, so a repeat of the same lookup hits at level 0.
- R3: A functional lookup (`req_functional`=1) changes no state. It makes no copy and does no retagging, and a repeat of it again resolves at level 1 with the stored tag.
- R4: Tag values are 1 instruction, 2 data and 3 unified. A non-functional hit on an entry whose tag lacks the access side (instruction for fetch, data otherwise) reports tag 3, and the entry keeps tag 3 from then on, including in the copy made by R2.
- R5: An insertion places the new entry in slot 0, moves every other entry down one slot and discards the last one. Of 9 fills on one side, the oldest leaves the 8-entry first level. Of 17 fills, it leaves the 16-entry second level.
- R6: A walk fill (`fill_valid`) enters the first-level array of `fill_kind`'s side and the second level. Its tag is 1 for a fetch fill and 2 otherwise.
- R7: `flush_sel` bit 0 clears the instruction array and bit 1 clears the data array. Any nonzero value also clears the second level. An array that is not selected keeps its entries.
- R8: A lookup accepted in the same cycle as a flush sees the flushed state. With `flush_sel`=3 it misses.
- R9: `vmid_wr` loads `vmid_wdata` into the VMID register of all three arrays together. Later walk fills carry the new VMID. Entries already held keep the VMID they were filled with, and lookups match on `req_vmid`.
- R10: A hit requires equal page number, VMID, hypervisor flag, secure flag, exception level and in-host flag. The ASID must also be equal unless `req_ignore_asid`=1.
- R11: A miss in both levels returns `rsp_hit`=0 two edges after acceptance. It sets `rsp_walk`=1 unless `req_prefetch`=1, in which case `rsp_walk`=0.
- R12: After reset all arrays are empty, every VMID register is 0, `rsp_valid`=0 and `req_ready`=1.
- R13: `req_ready` is 0 for exactly the one cycle in which a second-level lookup is pending. A request presented then is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write |
| req_functional | input | 1 | Lookup must not change state |
| req_prefetch | input | 1 | Request is a prefetch |
| req_vpn | input | 20 | Virtual page number |
| req_asid | input | 8 | Address-space ID |
| req_vmid | input | 8 | Virtual-machine ID |
| req_hyp | input | 1 | Hypervisor-mode lookup |
| req_secure | input | 1 | Secure lookup |
| req_el | input | 2 | Target exception level |
| req_ignore_asid | input | 1 | Treat ASID mismatch as match |
| req_in_host | input | 1 | Host-regime lookup |
| rsp_valid | output | 1 | Response this cycle |
| rsp_hit | output | 1 | Translation found |
| rsp_level | output | 1 | 0 first level, 1 second level |
| rsp_walk | output | 1 | Miss needing a page walk |
| rsp_ppn | output | 20 | Physical page number on hit |
| rsp_tag | output | 2 | Type tag of the hit entry |
| fill_valid | input | 1 | Walk fill |
| fill_kind | input | 2 | Access kind of the fill |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_asid | input | 8 | Fill ASID |
| fill_hyp | input | 1 | Fill hypervisor flag |
| fill_secure | input | 1 | Fill secure flag |
| fill_el | input | 2 | Fill exception level |
| fill_in_host | input | 1 | Fill in-host flag |
| fill_ppn | input | 20 | Fill physical page number |
| flush_sel | input | 2 | Flush target bits |
| vmid_wr | input | 1 | VMID register write |
| vmid_wdata | input | 8 | New VMID |

## Verification
The assertions watch the response timing on every cycle. A level-0 hit must follow an accepted request by one edge, and a level-1 response must follow the pending cycle. Ready may stay low for one cycle only. A walk request must come with a miss, a hit must carry a nonzero tag, and a lookup made during a full flush must not hit. Eviction order, retagging that persists, the absence of side effects from functional lookups, which arrays each flush reaches, and VMID stamping all depend on the contents of the arrays, so only the bench's fill, lookup and flush sequences can show them.

// File: rtl/tlbh_pkg.sv
package tlbh_pkg;

    parameter int VPN_W  = 20;
    parameter int PPN_W  = 20;
    parameter int ASID_W = 8;
    parameter int VMID_W = 8;
    parameter int EL_W   = 2;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_READ  = 2'd1;
    localparam logic [1:0] KIND_WRITE = 2'd2;

    localparam logic [1:0] TAG_INST = 2'd1;
    localparam logic [1:0] TAG_DATA = 2'd2;
    localparam logic [1:0] TAG_UNI  = 2'd3;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [VMID_W-1:0] vmid;
        logic              hyp;
        logic              secure;
        logic [EL_W-1:0]   el;
        logic              in_host;
        logic              ign_asid;
    } key_t;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [VMID_W-1:0] vmid;
        logic              hyp;
        logic              secure;
        logic [EL_W-1:0]   el;
        logic              in_host;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        tag;
    } entry_t;

    function automatic logic [1:0] side_need(input logic [1:0] kind);
        return (kind == KIND_FETCH) ? TAG_INST : TAG_DATA;
    endfunction

    function automatic logic key_match(input entry_t e, input key_t k);
        return e.valid && (e.vpn == k.vpn) && (e.vmid == k.vmid) &&
               (e.hyp == k.hyp) && (e.secure == k.secure) &&
               (e.el == k.el) && (e.in_host == k.in_host) &&
               (k.ign_asid || (e.asid == k.asid));
    endfunction

endpackage

// File: rtl/tlbh_array.sv
module tlbh_array
    import tlbh_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              vmid_wr,
    input  logic [VMID_W-1:0] vmid_wdata,
    input  logic              look_on,
    input  logic              look_promote,
    input  key_t              look_key,
    input  logic [1:0]        look_need,
    output logic              hit,
    output entry_t            hit_entry,
    input  logic              walk_on,
    input  entry_t            walk_entry,
    input  logic              copy_on,
    input  entry_t            copy_entry
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    entry_t             tbl_q [DEPTH];
    entry_t             tbl_d [DEPTH];
    entry_t             kept  [DEPTH];
    logic [DEPTH-1:0]   match;
    logic [IDX_W-1:0]   hit_idx;
    logic [VMID_W-1:0]  vmid_q;
    logic [VMID_W-1:0]  vmid_eff;
    entry_t             walk_set;
    entry_t             copy_set;

    // parallel comparators, one per slot; a flush in the same cycle hides all
    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
            assign match[s] = look_on && !flush && key_match(tbl_q[s], look_key);
        end
    endgenerate

    // lowest slot (most recently inserted) wins
    always_comb begin
        hit_idx = '0;
        for (int s = DEPTH - 1; s >= 0; s--) begin
            if (match[s]) hit_idx = IDX_W'(s);
        end
    end

    assign hit = |match;

    always_comb begin
        hit_entry = tbl_q[hit_idx];
        if (look_promote && ((hit_entry.tag & look_need) == 2'b00))
            hit_entry.tag = TAG_UNI;
    end

    assign vmid_eff = vmid_wr ? vmid_wdata : vmid_q;

    always_comb begin
        walk_set       = walk_entry;
        walk_set.vmid  = vmid_eff;
        walk_set.valid = 1'b1;
        copy_set       = copy_entry;
        copy_set.valid = 1'b1;
    end

    // flush, then retag, then shift-insert (walk fill ends up most recent)
    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            kept[s] = tbl_q[s];
            if (flush) kept[s].valid = 1'b0;
        end
        if (hit && look_promote) kept[hit_idx].tag = hit_entry.tag;
        for (int s = 0; s < DEPTH; s++) tbl_d[s] = kept[s];
        if (walk_on && copy_on) begin
            for (int s = 2; s < DEPTH; s++) tbl_d[s] = kept[s-2];
            tbl_d[1] = copy_set;
            tbl_d[0] = walk_set;
        end else if (walk_on || copy_on) begin
            for (int s = 1; s < DEPTH; s++) tbl_d[s] = kept[s-1];
            tbl_d[0] = walk_on ? walk_set : copy_set;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) tbl_q[s] <= '0;
            vmid_q <= '0;
        end else begin
            for (int s = 0; s < DEPTH; s++) tbl_q[s] <= tbl_d[s];
            if (vmid_wr) vmid_q <= vmid_wdata;
        end
    end

endmodule

// File: rtl/tlb2_hier.sv
module tlb2_hier
    import tlbh_pkg::*;
#(
    parameter int L1_DEPTH = 8,
    parameter int L2_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_functional,
    input  logic              req_prefetch,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [VMID_W-1:0] req_vmid,
    input  logic              req_hyp,
    input  logic              req_secure,
    input  logic [EL_W-1:0]   req_el,
    input  logic              req_ignore_asid,
    input  logic              req_in_host,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_level,
    output logic              rsp_walk,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [1:0]        rsp_tag,
    input  logic              fill_valid,
    input  logic [1:0]        fill_kind,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_hyp,
    input  logic              fill_secure,
    input  logic [EL_W-1:0]   fill_el,
    input  logic              fill_in_host,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [1:0]        flush_sel,
    input  logic              vmid_wr,
    input  logic [VMID_W-1:0] vmid_wdata
);

    localparam int SIDES = 2;   // 0 instruction, 1 data

    key_t       req_key;
    logic       req_fetch;
    logic [1:0] req_need;
    logic       accept;
    entry_t     fill_e;
    logic       fill_fetch;

    logic             pend_q;
    key_t             pend_key;
    logic             pend_fetch;
    logic             pend_func;
    logic             pend_pref;
    logic [1:0]       pend_need;

    logic [SIDES-1:0] l1_hit;
    entry_t           l1_hit_e [SIDES];
    logic             sel_hit;
    entry_t           sel_e;
    logic             l2_hit;
    entry_t           l2_hit_e;
    logic             refill;

    assign accept    = req_valid && !pend_q;
    assign req_ready = !pend_q;
    assign req_fetch = (req_kind == KIND_FETCH);
    assign req_need  = side_need(req_kind);

    always_comb begin
        req_key.vpn      = req_vpn;
        req_key.asid     = req_asid;
        req_key.vmid     = req_vmid;
        req_key.hyp      = req_hyp;
        req_key.secure   = req_secure;
        req_key.el       = req_el;
        req_key.in_host  = req_in_host;
        req_key.ign_asid = req_ignore_asid;
    end

    assign fill_fetch = (fill_kind == KIND_FETCH);

    always_comb begin
        fill_e.valid   = 1'b1;
        fill_e.vpn     = fill_vpn;
        fill_e.asid    = fill_asid;
        fill_e.vmid    = '0;               // stamped inside each array
        fill_e.hyp     = fill_hyp;
        fill_e.secure  = fill_secure;
        fill_e.el      = fill_el;
        fill_e.in_host = fill_in_host;
        fill_e.ppn     = fill_ppn;
        fill_e.tag     = side_need(fill_kind);
    end

    assign refill = pend_q && l2_hit && !pend_func;

    generate
        for (genvar g = 0; g < SIDES; g++) begin : g_l1
            localparam logic SIDE_FETCH = (g == 0);
            tlbh_array #(.DEPTH(L1_DEPTH)) u_arr (
                .clk          (clk),
                .rst          (rst),
                .flush        (flush_sel[g]),
                .vmid_wr      (vmid_wr),
                .vmid_wdata   (vmid_wdata),
                .look_on      (accept && (req_fetch == SIDE_FETCH)),
                .look_promote (!req_functional),
                .look_key     (req_key),
                .look_need    (req_need),
                .hit          (l1_hit[g]),
                .hit_entry    (l1_hit_e[g]),
                .walk_on      (fill_valid && (fill_fetch == SIDE_FETCH)),
                .walk_entry   (fill_e),
                .copy_on      (refill && (pend_fetch == SIDE_FETCH)),
                .copy_entry   (l2_hit_e)
            );
        end
    endgenerate

    tlbh_array #(.DEPTH(L2_DEPTH)) u_l2 (
        .clk          (clk),
        .rst          (rst),
        .flush        (|flush_sel),
        .vmid_wr      (vmid_wr),
        .vmid_wdata   (vmid_wdata),
        .look_on      (pend_q),
        .look_promote (!pend_func),
        .look_key     (pend_key),
        .look_need    (pend_need),
        .hit          (l2_hit),
        .hit_entry    (l2_hit_e),
        .walk_on      (fill_valid),
        .walk_entry   (fill_e),
        .copy_on      (1'b0),
        .copy_entry   ('0)
    );

    assign sel_hit = req_fetch ? l1_hit[0]   : l1_hit[1];
    assign sel_e   = req_fetch ? l1_hit_e[0] : l1_hit_e[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_key   <= '0;
            pend_fetch <= 1'b0;
            pend_func  <= 1'b0;
            pend_pref  <= 1'b0;
            pend_need  <= '0;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_level  <= 1'b0;
            rsp_walk   <= 1'b0;
            rsp_ppn    <= '0;
            rsp_tag    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_walk  <= 1'b0;
            if (pend_q) begin
                pend_q    <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_hit   <= l2_hit;
                rsp_level <= 1'b1;
                rsp_walk  <= !l2_hit && !pend_pref;
                rsp_ppn   <= l2_hit ? l2_hit_e.ppn : '0;
                rsp_tag   <= l2_hit ? l2_hit_e.tag : 2'b00;
            end else if (accept) begin
                if (sel_hit) begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_level <= 1'b0;
                    rsp_ppn   <= sel_e.ppn;
                    rsp_tag   <= sel_e.tag;
                end else begin
                    pend_q     <= 1'b1;
                    pend_key   <= req_key;
                    pend_fetch <= req_fetch;
                    pend_func  <= req_functional;
                    pend_pref  <= req_prefetch;
                    pend_need  <= req_need;
                end
            end
        end
    end

endmodule

// File: rtl/tlb2_hier_chk.sv
module tlb2_hier_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] flush_sel,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_level,
    input logic       rsp_walk,
    input logic [1:0] rsp_tag
);

    a_r1_l1_follows_accept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && !rsp_level) |-> $past(req_valid && req_ready));

    a_r2_l2_follows_pending: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_level) |-> $past(!req_ready));

    a_r13_pending_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

    a_r13_ready_drop_needs_request: assert property (@(posedge clk) disable iff (rst)
        $fell(req_ready) |-> $past(req_valid));

    a_r8_full_flush_misses: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && flush_sel == 2'b11) |=> !(rsp_valid && rsp_hit));

    a_r11_walk_only_on_miss: assert property (@(posedge clk) disable iff (rst)
        rsp_walk |-> (rsp_valid && !rsp_hit));

    a_r4_hit_has_tag: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (rsp_tag != 2'b00));

endmodule

bind tlb2_hier tlb2_hier_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .flush_sel (flush_sel),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_level (rsp_level),
    .rsp_walk  (rsp_walk),
    .rsp_tag   (rsp_tag)
);

// File: tb/sim_tlb2_hier.sv
module sim_tlb2_hier;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_functional = 0, req_prefetch = 0;
    logic [1:0]  req_kind = 0;
    logic [19:0] req_vpn = 0;
    logic [7:0]  req_asid = 0, req_vmid = 0;
    logic        req_hyp = 0, req_secure = 0, req_ignore_asid = 0, req_in_host = 0;
    logic [1:0]  req_el = 0;
    logic        req_ready, rsp_valid, rsp_hit, rsp_level, rsp_walk;
    logic [19:0] rsp_ppn;
    logic [1:0]  rsp_tag;
    logic        fill_valid = 0;
    logic [1:0]  fill_kind = 0;
    logic [19:0] fill_vpn = 0, fill_ppn = 0;
    logic [7:0]  fill_asid = 0;
    logic        fill_hyp = 0, fill_secure = 0, fill_in_host = 0;
    logic [1:0]  fill_el = 0;
    logic [1:0]  flush_sel = 0;
    logic        vmid_wr = 0;
    logic [7:0]  vmid_wdata = 0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // context used by fill and lookup tasks
    logic [7:0] g_asid = 8'd1, g_vmid = 8'd3;
    logic       g_hyp = 0, g_sec = 0, g_inh = 0, g_ign = 0, g_pref = 0;
    logic [1:0] g_el = 2'd1, g_fl = 2'd0;

    // captured lookup result
    int         r_lat;
    logic       r_hit, r_lvl, r_walk, r_rdy_mid;
    logic [19:0] r_ppn;
    logic [1:0] r_tag;

    localparam logic [1:0] FETCH = 2'd0, READ = 2'd1, WRITE = 2'd2;

    always #10 clk = ~clk;   // 50 MHz

    tlb2_hier u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_functional(req_functional), .req_prefetch(req_prefetch),
        .req_vpn(req_vpn), .req_asid(req_asid), .req_vmid(req_vmid), .req_hyp(req_hyp),
        .req_secure(req_secure), .req_el(req_el), .req_ignore_asid(req_ignore_asid),
        .req_in_host(req_in_host), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_level(rsp_level), .rsp_walk(rsp_walk), .rsp_ppn(rsp_ppn), .rsp_tag(rsp_tag),
        .fill_valid(fill_valid), .fill_kind(fill_kind), .fill_vpn(fill_vpn),
        .fill_asid(fill_asid), .fill_hyp(fill_hyp), .fill_secure(fill_secure),
        .fill_el(fill_el), .fill_in_host(fill_in_host), .fill_ppn(fill_ppn),
        .flush_sel(flush_sel), .vmid_wr(vmid_wr), .vmid_wdata(vmid_wdata)
    );

    function automatic logic [19:0] pp(input logic [19:0] v);
        return v * 20'd3 + 20'd7;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic [1:0] kind, input logic [19:0] vpn);
        @(negedge clk);
        fill_valid = 1; fill_kind = kind; fill_vpn = vpn; fill_ppn = pp(vpn);
        fill_asid = g_asid; fill_hyp = g_hyp; fill_secure = g_sec;
        fill_el = g_el; fill_in_host = g_inh;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic flush(input logic [1:0] sel);
        @(negedge clk);
        flush_sel = sel;
        @(negedge clk);
        flush_sel = 0;
    endtask

    task automatic set_vmid(input logic [7:0] v);
        @(negedge clk);
        vmid_wr = 1; vmid_wdata = v;
        @(negedge clk);
        vmid_wr = 0;
    endtask

    task automatic look(input logic [1:0] kind, input logic [19:0] vpn, input logic func);
        @(negedge clk);
        req_valid = 1; req_kind = kind; req_vpn = vpn; req_functional = func;
        req_prefetch = g_pref; req_asid = g_asid; req_vmid = g_vmid; req_hyp = g_hyp;
        req_secure = g_sec; req_el = g_el; req_ignore_asid = g_ign; req_in_host = g_inh;
        flush_sel = g_fl;
        @(negedge clk);
        req_valid = 0; flush_sel = 0;
        r_rdy_mid = req_ready;
        r_lat = 0;
        if (!rsp_valid) begin
            @(negedge clk);
            if (rsp_valid) r_lat = 2;
        end else begin
            r_lat = 1;
        end
        r_hit = rsp_hit; r_lvl = rsp_level; r_walk = rsp_walk;
        r_ppn = rsp_ppn; r_tag = rsp_tag;
    endtask

    // lookup with expected latency (1 = level 0, 2 = level 1) and tag; tag 0 = miss
    task automatic expect_look(input string req, input logic [1:0] kind,
                               input logic [19:0] vpn, input logic func,
                               input int e_lat, input int e_tag);
        look(kind, vpn, func);
        chk(req, r_lat, e_lat);
        chk(req, r_hit, (e_tag != 0));
        if (e_tag != 0) begin
            chk(req, r_lvl, (e_lat == 2));
            chk(req, r_ppn, pp(vpn));
            chk(req, r_tag, e_tag);
        end else begin
            chk(req, r_walk, !g_pref);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R12: reset state
        chk("R12 rsp_valid", rsp_valid, 0);
        chk("R12 req_ready", req_ready, 1);
        expect_look("R12 empty", READ, 20'h5, 0, 2, 0);

        // R9 write VMID 3, R6 fill data side, R1 level-0 hits
        set_vmid(8'd3);
        for (int i = 0; i < 8; i++) fill(READ, 20'(i));
        for (int i = 0; i < 8; i++) expect_look("R1 R6 data hit", (i % 2) ? WRITE : READ, 20'(i), 0, 1, 2);

        // R10 key mismatches, one field at a time
        for (int f = 0; f < 5; f++) begin
            g_vmid = (f == 0) ? 8'd4 : 8'd3;
            g_hyp  = (f == 1);
            g_sec  = (f == 2);
            g_el   = (f == 3) ? 2'd2 : 2'd1;
            g_inh  = (f == 4);
            expect_look("R10 field mismatch", READ, 20'h2, 0, 2, 0);
            chk("R13 ready low while pending", r_rdy_mid, 0);
        end
        g_vmid = 8'd3; g_hyp = 0; g_sec = 0; g_el = 2'd1; g_inh = 0;
        g_asid = 8'd2;
        expect_look("R10 asid mismatch", READ, 20'h2, 0, 2, 0);
        g_ign = 1;
        expect_look("R10 ignore asid", READ, 20'h2, 0, 1, 2);
        g_ign = 0; g_asid = 8'd1;

        // R4 promotion on cross-type L2 hit, R2 refill
        expect_look("R4 R2 promote", FETCH, 20'h0, 0, 2, 3);
        expect_look("R2 R4 refilled unified", FETCH, 20'h0, 0, 1, 3);
        // R3 functional lookups leave no trace
        expect_look("R3 functional", FETCH, 20'h1, 1, 2, 2);
        expect_look("R3 no refill no retag", FETCH, 20'h1, 1, 2, 2);
        expect_look("R4 data copy untouched", READ, 20'h0, 0, 1, 2);

        // R11 prefetch miss
        g_pref = 1;
        expect_look("R11 prefetch no walk", READ, 20'h100, 0, 2, 0);
        g_pref = 0;
        expect_look("R11 miss walk", READ, 20'h100, 0, 2, 0);

        // R5 MRU ordering and eviction
        flush(2'b11);
        for (int i = 0; i < 9; i++) fill(FETCH, 20'h10 + 20'(i));
        for (int i = 0; i < 9; i++)
            expect_look("R5 l1 evict", FETCH, 20'h10 + 20'(i), 1, (i == 0) ? 2 : 1, 1);
        for (int i = 9; i < 17; i++) fill(FETCH, 20'h10 + 20'(i));
        expect_look("R5 l2 evict", FETCH, 20'h10, 1, 2, 0);
        expect_look("R5 l2 keeps", FETCH, 20'h11, 1, 2, 1);
        expect_look("R5 l1 newest", FETCH, 20'h19, 1, 1, 1);

        // R7 flush targeting
        flush(2'b11);
        fill(FETCH, 20'h40); fill(READ, 20'h41);
        flush(2'b10);
        expect_look("R7 data flush keeps inst", FETCH, 20'h40, 1, 1, 1);
        expect_look("R7 data flush clears", READ, 20'h41, 1, 2, 0);
        flush(2'b11);
        fill(FETCH, 20'h40); fill(READ, 20'h41);
        flush(2'b01);
        expect_look("R7 inst flush clears", FETCH, 20'h40, 1, 2, 0);
        expect_look("R7 inst flush keeps data", READ, 20'h41, 1, 1, 2);
        flush(2'b11);
        expect_look("R7 full flush", READ, 20'h41, 1, 2, 0);

        // R8 lookup in same cycle as flush
        fill(READ, 20'h50);
        g_fl = 2'b01;
        expect_look("R8 inst flush same cycle", READ, 20'h50, 0, 1, 2);
        g_fl = 2'b11;
        expect_look("R8 full flush same cycle", READ, 20'h50, 0, 2, 0);
        g_fl = 2'b00;

        // R9 VMID broadcast and stamping
        fill(READ, 20'h61);
        set_vmid(8'd7);
        fill(READ, 20'h60);
        fill(FETCH, 20'h62);
        g_vmid = 8'd7;
        expect_look("R9 new vmid data", READ, 20'h60, 1, 1, 2);
        expect_look("R9 new vmid inst", FETCH, 20'h62, 1, 1, 1);
        g_vmid = 8'd3;
        expect_look("R9 old vmid no match", READ, 20'h60, 1, 2, 0);
        expect_look("R9 old entry keeps vmid", READ, 20'h61, 1, 1, 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule